// File: doc/BRIEF.md
# Pausable Pseudorandom Capture Peripheral

This block runs a 16-bit pseudorandom generator on every clock. It does not send that fast-changing word straight to its outputs. A reloading interval counter raises a strobe at a rate software chooses, and on each strobe a holding register takes a snapshot of the generator. The outputs show that snapshot, so they change slowly enough for a person to follow. Slices of the held word drive two seven-segment outputs and two four-lamp outputs.

A pushbutton input freezes the snapshot so that a person can read the displayed value. Software reaches the block through a small word-addressed register port with a combinational read. It sets the interval length, and it reads both the interval and the held word.

Top module: `lfsr_capture_periph`

## Requirements
- R1: The generator is a 16-bit Fibonacci shift register. Its reset value is 0xACE1. On each clock it shifts left by one, and the new bit 0 is the XOR of old bits 15, 14, 12 and 3 (mask 0xD008). An all-zero state reloads 0xACE1.
- R2: Starting from the seed, the generator visits 65535 distinct states before it repeats.
- R3: An interval counter starts at 0 after reset and counts clocks. In the cycle where it equals the active limit minus one it raises a strobe and returns to 0. When the strobe is not masked, the held word takes the generator value at that edge. At no other edge does the held word change.
- R4: The interval register is at byte offset 0x0 (word index 0). It is written in full, reads back the last value written, and resets to the parameter PERIOD_RST (default 8,000,000).
- R5: An interval value of zero acts as a limit of one, so the snapshot then updates on every clock.
- R6: A newly written interval becomes the active limit only at the counter's next reload. The reload in progress still uses the old limit.
- R7: The pause input passes through two synchronizing flops. While the synchronized pause is high, the strobe is masked and the held word keeps its value. The counter and the generator keep running.
- R8: The held word reads at byte offset 0x4 (word index 1), zero-extended to 32 bits. Writes to that offset are ignored. Every other offset reads zero.
- R9: Red lamps carry held bits [15:12] and green lamps carry bits [3:0]. The left segment output carries bits [15:9] and the right segment output carries bits [6:0].
- R10: After reset the held word is zero, so every display output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_btn | input | 1 | Asynchronous freeze request |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| hex_left | output | 7 | Segment value from held bits [15:9] |
| hex_right | output | 7 | Segment value from held bits [6:0] |
| led_red | output | 4 | Lamps from held bits [15:12] |
| led_green | output | 4 | Lamps from held bits [3:0] |

## Verification
The checker assumes that inputs change only away from the rising edge and that the interval value is never wider than the bus word. It also assumes that a write lands in a single cycle. The bench drives every input at the falling edge and holds each write for exactly one cycle. It keeps a cycle-level reference of the counter, the generator and the synchronizer. It sweeps interval values 0 through 7, with pause patterns that arrive both between strobes and on strobe cycles. It then runs one full generator period at interval one.

// File: rtl/lfsr_capture_pkg.sv
package lfsr_capture_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD  = 2'd0,
    SEL_CAPTURE = 2'd1,
    SEL_NONE    = 2'd2
  } reg_sel_e;

  // Word index of the register port to register select
  function automatic reg_sel_e decode_word(input logic [1:0] word_idx);
    case (word_idx)
      2'd0:    return SEL_PERIOD;
      2'd1:    return SEL_CAPTURE;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hD008,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_q
);
  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    if (s == '0) return SEED;
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= step(state_q);
  end
endmodule

// File: rtl/period_timer.sv
module period_timer #(
  parameter int W     = 32,
  parameter int RST_P = 8000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] period_in,
  output logic         strobe,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] limit_q
);
  localparam logic [W-1:0] RST_LIM = (RST_P == 0) ? W'(1) : W'(RST_P);

  // Zero is treated as a one-cycle interval
  function automatic logic [W-1:0] eff_limit(input logic [W-1:0] p);
    return (p == '0) ? W'(1) : p;
  endfunction

  assign strobe = (cnt_q == limit_q - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      limit_q <= RST_LIM;
    end else if (strobe) begin
      cnt_q   <= '0;
      limit_q <= eff_limit(period_in);
    end else begin
      cnt_q   <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/pause_sync.sv
module pause_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/lfsr_capture_periph.sv
module lfsr_capture_periph
  import lfsr_capture_pkg::*;
#(
  parameter int              LFSR_W      = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK  = 16'hD008,
  parameter logic [LFSR_W-1:0] SEED      = 16'hACE1,
  parameter int              PERIOD_W    = 32,
  parameter int              PERIOD_RST  = 8000000,
  parameter int              ADDR_W      = 4,
  parameter int              DATA_W      = 32,
  parameter int              HEX_W       = 7,
  parameter int              LED_W       = 4,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause_btn,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [HEX_W-1:0]  hex_left,
  output logic [HEX_W-1:0]  hex_right,
  output logic [LED_W-1:0]  led_red,
  output logic [LED_W-1:0]  led_green
);
  localparam logic [PERIOD_W-1:0] PERIOD_INIT = PERIOD_W'(PERIOD_RST);

  // Named internal events, also used by the checker
  logic [LFSR_W-1:0]   lfsr_q;
  logic [LFSR_W-1:0]   cap_q;
  logic [PERIOD_W-1:0] period_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] limit_q;
  logic                cap_strobe;
  logic                pause_s;
  logic                cap_fire;
  reg_sel_e            sel;

  lfsr_gen #(.W(LFSR_W), .TAPS(TAP_MASK), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state_q(lfsr_q)
  );

  period_timer #(.W(PERIOD_W), .RST_P(PERIOD_RST)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_in(period_q),
    .strobe(cap_strobe), .cnt_q(cnt_q), .limit_q(limit_q)
  );

  pause_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pause_btn), .sync_out(pause_s)
  );

  assign cap_fire = cap_strobe && !pause_s;
  assign sel      = decode_word(bus_addr[3:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= PERIOD_INIT;
      cap_q    <= '0;
    end else begin
      if (bus_wr_en && sel == SEL_PERIOD) period_q <= bus_wdata[PERIOD_W-1:0];
      if (cap_fire)                       cap_q    <= lfsr_q;
    end
  end

  always_comb begin
    case (sel)
      SEL_PERIOD:  bus_rdata = DATA_W'(period_q);
      SEL_CAPTURE: bus_rdata = DATA_W'(cap_q);
      default:     bus_rdata = '0;
    endcase
  end

  assign led_red   = cap_q[LFSR_W-1 -: LED_W];
  assign led_green = cap_q[LED_W-1:0];
  assign hex_left  = cap_q[LFSR_W-1 -: HEX_W];
  assign hex_right = cap_q[HEX_W-1:0];
endmodule

// File: rtl/lfsr_capture_chk.sv
module lfsr_capture_chk #(
  parameter int LFSR_W   = 16,
  parameter int PERIOD_W = 32,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int OUT_W    = 22
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cap_strobe,
  input logic                pause_s,
  input logic [LFSR_W-1:0]   lfsr_q,
  input logic [LFSR_W-1:0]   cap_q,
  input logic [PERIOD_W-1:0] period_q,
  input logic [PERIOD_W-1:0] cnt_q,
  input logic [PERIOD_W-1:0] limit_q,
  input logic                bus_wr_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [OUT_W-1:0]    outs
);
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != '0); // R1
  AST_LFSR_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lfsr_q[LFSR_W-1:1] == $past(lfsr_q[LFSR_W-2:0])); // R1
  AST_CAP_TAKES_LFSR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_strobe && !pause_s) |=> cap_q == $past(lfsr_q)); // R3
  AST_CAP_HOLDS_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |=> $stable(cap_q)); // R3
  AST_STROBE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> cnt_q == '0); // R3
  AST_PERIOD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr[ADDR_W-1:2] == '0) |=> period_q == $past(bus_wdata[PERIOD_W-1:0])); // R4
  AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) limit_q != '0); // R5
  AST_LIMIT_ONLY_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |=> $stable(limit_q)); // R6
  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < limit_q); // R6
  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    pause_s |=> $stable(cap_q)); // R7
  AST_OUTS_FOLLOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cap_q) |-> $stable(outs)); // R9
endmodule

bind lfsr_capture_periph lfsr_capture_chk #(
  .LFSR_W(LFSR_W), .PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OUT_W(2*HEX_W + 2*LED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_strobe(cap_strobe), .pause_s(pause_s),
  .lfsr_q(lfsr_q), .cap_q(cap_q), .period_q(period_q), .cnt_q(cnt_q),
  .limit_q(limit_q), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .outs({hex_left, hex_right, led_red, led_green})
);

// File: tb/test_lfsr_capture_periph.sv
module test_lfsr_capture_periph;
  localparam int CLK_PERIOD = 10;
  localparam int RST_P      = 20;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pause_btn = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  hex_left, hex_right;
  logic [3:0]  led_red, led_green;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  // Reference model state
  logic [15:0] m_lfsr, m_cap;
  logic [31:0] m_period, m_cnt, m_lim;
  logic        m_p1, m_p2;

  lfsr_capture_periph #(.PERIOD_RST(RST_P)) i_lfsr_capture_periph (
    .clk(clk), .rst_n(rst_n), .pause_btn(pause_btn), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hex_left(hex_left), .hex_right(hex_right), .led_red(led_red), .led_green(led_green)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_next(input logic [15:0] s);
    logic fb;
    fb = ($countones(s & 16'hD008) % 2) == 1;
    return (s << 1) | {15'd0, fb};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_lfsr <= 16'hACE1; m_cap <= '0; m_period <= RST_P;
      m_cnt <= '0; m_lim <= RST_P; m_p1 <= 1'b0; m_p2 <= 1'b0;
    end else begin
      if (m_cnt + 1 == m_lim) begin
        m_cnt <= '0;
        m_lim <= (m_period == 0) ? 32'd1 : m_period;
        if (!m_p2) m_cap <= m_lfsr;
      end else begin
        m_cnt <= m_cnt + 1;
      end
      m_lfsr <= ref_next(m_lfsr);
      m_p1 <= pause_btn; m_p2 <= m_p1;
      if (bus_wr_en && bus_addr[3:2] == 2'd0) m_period <= bus_wdata;
    end
  end

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (model_on) begin
      logic [31:0] exp_rd;
      exp_rd = (bus_addr[3:2] == 2'd0) ? m_period :
               (bus_addr[3:2] == 2'd1) ? {16'd0, m_cap} : 32'd0;
      chk(bus_rdata == exp_rd, "R3/R4/R8 read", bus_rdata, exp_rd);
      chk({led_red, led_green} == {m_cap[15:12], m_cap[3:0]}, "R9 lamps",
          {24'd0, led_red, led_green}, {24'd0, m_cap[15:12], m_cap[3:0]});
      chk({hex_left, hex_right} == {m_cap[15:9], m_cap[6:0]}, "R9 segments",
          {18'd0, hex_left, hex_right}, {18'd0, m_cap[15:9], m_cap[6:0]});
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk({hex_left, hex_right, led_red, led_green} == '0, "R10 outputs zero",
        {10'd0, hex_left, hex_right, led_red, led_green}, 32'd0);
    bus_addr = 4'h0;
    #1 chk(bus_rdata == RST_P, "R4 reset period", bus_rdata, RST_P);
    bus_addr = 4'h4;
    #1 chk(bus_rdata == 0, "R10 held word zero", bus_rdata, 0);
    model_on = 1'b1;
    wait_cycles(70); // R3 default interval, R1 sequence through captures

    // R5 R6 R7 sweep of interval values with pause patterns
    for (int p = 0; p < 8; p++) begin
      write_reg(4'h0, p);
      bus_addr = 4'h4;
      wait_cycles(3 * (p + 2));
      pause_btn = 1'b1;               // R7 freeze
      wait_cycles(2 * p + 5);
      pause_btn = 1'b0;
      wait_cycles(p + 1);
      pause_btn = (p % 2) == 1;       // short pulse
      wait_cycles(1);
      pause_btn = 1'b0;
      wait_cycles(2 * (p + 2));
      bus_addr = 4'h0;
      wait_cycles(1);
    end

    // R8: writes to the held word are ignored, other offsets read zero
    write_reg(4'h4, 32'hFFFF_FFFF);
    bus_addr = 4'h4; wait_cycles(2);
    write_reg(4'h8, 32'h1234_5678);
    bus_addr = 4'h8; wait_cycles(2);
    bus_addr = 4'hC; wait_cycles(2);
    bus_addr = 4'h0; wait_cycles(2);

    // R2: full generator period at interval one
    write_reg(4'h0, 32'd1);
    wait_cycles(10);
    begin
      logic [15:0] first;
      int n;
      first = {led_red, m_cap[11:0]};
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while ({led_red, m_cap[11:0]} != first && n < 70000);
      chk(n == 65535, "R2 sequence length", n, 65535);
    end
    model_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule